// File: doc/BRIEF.md
# Byte-Lane Masked Simple Dual-Port RAM

A synchronous memory with one write port and one read port sharing a single clock. Each write carries an address, a data word, a write enable and a lane mask with one bit per byte, so a single write can update any subset of the bytes in a word. The read port takes an address and a read enable and returns the addressed word one clock later. An optional output register can be switched in, which makes the read two clocks.

When the read port addresses the word that the write port is updating on the same edge, a parameter chooses the result. In old-data mode the read returns the word as it was before that write. In don't-care mode the read returns unknown data, which lets the memory be mapped onto cheaper storage. The read output comes out of reset cleared in both register modes. The storage cells themselves are never cleared, so a read of a word that was never written returns unknown data, and reset does not destroy stored words.

Top module: `sdp_lane_ram`

## Requirements
- R1: While reset is asserted and after it is released, `rd_data` is zero until a read completes, with the output register both bypassed and used.
- R2: With `OUT_REG`=0, a read enabled at clock edge k shows the addressed word on `rd_data` right after edge k.
- R3: With `OUT_REG`=1, a read enabled at edge k shows the word right after edge k+1; right after edge k the output still shows its previous value.
- R4: When `rd_en` is low, the read output keeps the last word read, even if that word is written meanwhile.
- R5: Mask bit 0 gates byte `wr_data[7:0]` and mask bit 1 gates byte `wr_data[15:8]`; a byte whose mask bit is 0 keeps its stored value (BBBB written with mask 01 over AAAA gives AABB).
- R6: Mask 11 replaces the whole word; mask 00 changes nothing even with `wr_en` high.
- R7: In old-data mode (`OLD_DATA`=1), a read of the address being written on the same edge returns the contents from before that write, whatever the mask.
- R8: In don't-care mode (`OLD_DATA`=0), reads that do not collide with a write return the same data as in old-data mode; a colliding read returns unknown data.
- R9: A word written at edge k is returned by a read of that address enabled at edge k+1.
- R10: Reset clears only the read output; words written before reset are returned unchanged by reads after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read output |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | LANES | Per-byte write enable, bit i gates byte i |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |

## Verification
The bench aims at same-edge collisions with full and partial masks, where a design that forwarded the write data or merged it in would show the new word or a mix instead of the old one. It runs masks 01, 10, 00 and 11 over known words, catching swapped lanes, a zero mask that still writes, or a merge that clears the unmasked byte. It checks that the output is zero after reset in both register modes yet stored words survive reset, which exposes a reset that wipes storage or misses the output register, and it holds `rd_en` low across a write to catch an output that follows the array instead of latching. Three instances (bypassed, registered, don't-care) are run together against a shadow model so that an off-by-one latency shows as a one-cycle skew on every read.

// File: rtl/sdp_lane_ram.sv
`timescale 1ns/1ps
module sdp_lane_ram #(
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int DEPTH    = 256,
  parameter int OUT_REG  = 0,
  parameter int OLD_DATA = 1,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int LANES   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              hit;

  assign hit = wr_en && (|wr_mask) && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= (hit && OLD_DATA == 0) ? 'x : mem[rd_addr];
  end

  generate
    if (OUT_REG != 0) begin : g_oreg
      logic [DATA_W-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= rd_q;
      end
      assign rd_data = out_q;

      p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en ##1 !rd_en |=> $stable(rd_data));
    end else begin : g_direct
      assign rd_data = rd_q;

      p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    end
  endgenerate

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> rd_data == '0);

  p_hold_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

  p_wr_then_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && (&$past(wr_mask)) && rd_en && rd_addr == $past(wr_addr)
    && !(hit && OLD_DATA == 0) |=> rd_q == $past(wr_data, 2));

endmodule

// File: tb/sim_sdp_lane_ram.sv
`timescale 1ns/1ps
module sim_sdp_lane_ram;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [1:0] wr_mask = 0;
  logic [15:0] d0, d1, d2;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sdp_lane_ram #(.OUT_REG(0), .OLD_DATA(1)) u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .wr_mask, .rd_en, .rd_addr, .rd_data(d0));
  sdp_lane_ram #(.OUT_REG(1), .OLD_DATA(1)) u1 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .wr_mask, .rd_en, .rd_addr, .rd_data(d1));
  sdp_lane_ram #(.OUT_REG(0), .OLD_DATA(0)) u2 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .wr_mask, .rd_en, .rd_addr, .rd_data(d2));

  logic [15:0] shadow [256];
  bit          known  [256];
  logic [15:0] e0, e1, e2;
  bit          v0, v1, v2;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare just after it
  task automatic cyc(string tag, bit we, logic [7:0] wa, logic [15:0] wd, logic [1:0] wm,
                     bit re, logic [7:0] ra);
    bit coll;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; wr_mask = wm; rd_en = re; rd_addr = ra;
    @(posedge clk);
    coll = we && (wm != 0) && (wa == ra);
    e1 = e0; v1 = v0;
    if (re) begin
      e0 = shadow[ra]; v0 = known[ra];
      e2 = shadow[ra]; v2 = known[ra] && !coll;
    end
    if (we) begin
      if (wm[0]) shadow[wa][7:0]  = wd[7:0];
      if (wm[1]) shadow[wa][15:8] = wd[15:8];
      if (wm == 2'b11) known[wa] = 1;
    end
    #1;
    if (v0) chk({tag, " bypassed"}, d0, e0);
    if (v1) chk({tag, " registered"}, d1, e1);
    if (v2) chk({tag, " dont-care"}, d2, e2);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    repeat (2) @(posedge clk);
    #1;
    chk({tag, " bypassed in reset"}, d0, 16'h0);
    chk({tag, " registered in reset"}, d1, 16'h0);
    @(negedge clk);
    rst_n = 1;
    e0 = 0; e1 = 0; e2 = 0; v0 = 1; v1 = 1; v2 = 1;
  endtask

  task automatic t_reset;
    do_reset("R1");
    cyc("R1 idle after reset", 0, 0, 0, 0, 0, 0);
    cyc("R1 idle after reset", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_write_read;
    cyc("R9 write 5", 1, 8'd5, 16'h1234, 2'b11, 0, 0);
    // bypassed sees 1234 now (R2); registered still shows 0 (R3)
    cyc("R2 R3 R9 read 5", 0, 0, 0, 0, 1, 8'd5);
    cyc("R3 registered follows", 0, 0, 0, 0, 0, 0);
    cyc("R9 write 6", 1, 8'd6, 16'h5678, 2'b11, 0, 0);
    cyc("R8 R9 read 6", 0, 0, 0, 0, 1, 8'd6);
    cyc("R8 read 5", 0, 0, 0, 0, 1, 8'd5);
    cyc("R3 drain", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mask;
    cyc("R6 full AAAA", 1, 8'd7, 16'hAAAA, 2'b11, 0, 0);
    cyc("R5 low lane BBBB", 1, 8'd7, 16'hBBBB, 2'b01, 0, 0);
    cyc("R5 read AABB", 0, 0, 0, 0, 1, 8'd7);
    chk("R5 low lane only", d0, 16'hAABB);
    cyc("R5 high lane CCCC", 1, 8'd7, 16'hCCCC, 2'b10, 0, 0);
    cyc("R5 read CCBB", 0, 0, 0, 0, 1, 8'd7);
    chk("R5 high lane only", d0, 16'hCCBB);
    cyc("R6 mask 00 DDDD", 1, 8'd7, 16'hDDDD, 2'b00, 0, 0);
    cyc("R6 read after mask 00", 0, 0, 0, 0, 1, 8'd7);
    chk("R6 mask 00 no change", d0, 16'hCCBB);
    cyc("R6 full EEEE", 1, 8'd7, 16'hEEEE, 2'b11, 0, 0);
    cyc("R6 read EEEE", 0, 0, 0, 0, 1, 8'd7);
    chk("R6 full word", d0, 16'hEEEE);
  endtask

  task automatic t_hold;
    cyc("R4 read 5", 0, 0, 0, 0, 1, 8'd5);
    cyc("R4 hold", 0, 0, 0, 0, 0, 8'd7);
    cyc("R4 hold across write", 1, 8'd5, 16'h0F0F, 2'b11, 0, 8'd5);
    cyc("R4 hold", 0, 0, 0, 0, 0, 8'd6);
    chk("R4 bypassed held", d0, 16'h1234);
    chk("R4 registered held", d1, 16'h1234);
    cyc("R4 new read", 0, 0, 0, 0, 1, 8'd5);
    chk("R4 read after hold", d0, 16'h0F0F);
  endtask

  task automatic t_collision;
    cyc("R7 seed 9", 1, 8'd9, 16'h1111, 2'b11, 0, 0);
    cyc("R7 collide full", 1, 8'd9, 16'h2222, 2'b11, 1, 8'd9);
    chk("R7 old data full mask", d0, 16'h1111);
    cyc("R7 collide partial", 1, 8'd9, 16'h3333, 2'b01, 1, 8'd9);
    chk("R7 old data partial mask", d0, 16'h2222);
    cyc("R7 R8 read after", 0, 0, 0, 0, 1, 8'd9);
    chk("R7 new data next read", d0, 16'h2233);
    chk("R8 dont-care non-colliding", d2, 16'h2233);
    cyc("R3 drain", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset_keep;
    do_reset("R10");
    cyc("R1 R10 cleared", 0, 0, 0, 0, 0, 0);
    chk("R1 bypassed zero", d0, 16'h0);
    chk("R1 registered zero", d1, 16'h0);
    cyc("R10 read kept word", 0, 0, 0, 0, 1, 8'd7);
    chk("R10 storage kept", d0, 16'hEEEE);
    cyc("R10 registered", 0, 0, 0, 0, 0, 0);
    chk("R10 registered kept", d1, 16'hEEEE);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 256; i++) known[i] = 0;
    e0 = 0; e1 = 0; e2 = 0; v0 = 0; v1 = 0; v2 = 0;
    t_reset();
    t_write_read();
    t_mask();
    t_hold();
    t_collision();
    t_reset_keep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule